// File: doc/BRIEF.md
# Supply-Loss Write Guard Sequencer

This block sits between a host and a battery-backed static memory. It watches two digital flags from external supply comparators: one says the supply is below the deselect threshold, the other says it is below the battery switchover threshold. From these flags and the host's select, write and output-enable strobes, it produces the gated select, write and output-enable that reach the memory. It also produces an output-disable for the data pins, a battery-select and a protection indicator.

When the supply starts to fail, a host access that is already under way may run to completion. A bounded window, counted in clock cycles, limits how long that can take; when the window closes, protection is forced. While protected, the host's strobes have no effect. Once the supply is good again, protection stays in force for a long recovery interval before normal access returns. The battery is selected only after the supply has been seen good at least once since a cold reset. Both intervals are parameters given in clock cycles. A fast-simulation parameter divides them so that a bench can run through them.

Top module: `supply_guard_seq`

## Requirements
- R1: While the cold reset `rstN` is low and in the cycle after it is released, `protectOn` is 1, `battSel` is 0, `memSel`, `memWr` and `memOe` are 0 and `outDisable` is 1, whatever the host drives.
- R2: In normal operation: `memSel` equals `hostSel`; `memWr` is `hostSel & hostWr`; `memOe` is `hostSel & hostOe & ~hostWr`; `outDisable` is the inverse of `memOe`.
- R3: If a failing supply (either flag 1) is sampled while `hostSel` is 0, `protectOn` is 1 after that same clock edge.
- R4: If a failing supply is sampled while `hostSel` is 1, the access continues: the strobes keep passing to the memory. Protection begins at the first edge that samples `hostSel` at 0.
- R5: If the access is still active, protection is forced at the edge that closes the window. That edge is the (WP+1)-th edge counted from the edge that first sampled the failure, where WP is the effective protect window in cycles.
- R6: While `protectOn` is 1, `memSel`, `memWr` and `memOe` are 0 and `outDisable` is 1, whatever the host drives.
- R7: While protected, with both flags 1 and the supply seen good since reset, `battSel` becomes 1 after the next edge. It returns to 0 after the first edge that samples the switchover flag at 0.
- R8: After a cold reset, `battSel` stays 0 under both flags until an edge has sampled both flags at 0.
- R9: A switchover flag of 1 while the deselect flag is 0 counts as a supply failure: it causes protection, never battery selection.
- R10: Recovery applies when both flags are sampled 0 while protected. `protectOn` then falls on the (ER+1)-th edge counted from that sample, where ER is the effective recovery interval in cycles.
- R11: A failure sampled during recovery returns the block to protected and discards the recovery time counted so far. The full interval applies again after the next good sample.
- R12: With `FAST_SIM` set to 1, WP and ER are `WP_CYCLES/SCALE_DIV` and `ER_CYCLES/SCALE_DIV`, each at least 1. Otherwise they are `WP_CYCLES` and `ER_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Cold reset, active low |
| lowDeselect | input | 1 | Supply below deselect threshold (synchronous) |
| lowSwitch | input | 1 | Supply below battery switchover threshold (synchronous) |
| hostSel | input | 1 | Host memory select, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostOe | input | 1 | Host output enable, active high |
| memSel | output | 1 | Gated select to memory |
| memWr | output | 1 | Gated write to memory |
| memOe | output | 1 | Gated output enable to memory |
| outDisable | output | 1 | Data pins high impedance when 1 |
| battSel | output | 1 | Battery powers the memory when 1 |
| protectOn | output | 1 | Memory deselected and write-protected |

## Verification
The assertions check a set of invariants on every cycle. No write, select or output enable reaches the memory while protected. The pending state exists only while a host access continues. A closed window or a failure during recovery leads to protection on the next edge. The battery is selected only after both flags were sampled. The interval counter never passes its largest limit. Other behaviours depend on history over many cycles, and only the bench scenarios show them. These are the exact window and recovery lengths, the restart of recovery after a glitch, the battery isolation before the first good supply, and the pass-through table in normal operation.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_PENDING = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } guardState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic gateOpen;
    logic protect;
  } guardStrobe_t;

  function automatic int scaleLen(input int cycles, input int fastSim, input int div);
    int r;
    if (fastSim != 0) begin
      r = cycles / div;
      if (r < 1) r = 1;
    end else begin
      r = cycles;
    end
    return r;
  endfunction

endpackage

// File: rtl/supply_guard_dp.sv
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int WP_LEN = 1000,
  parameter int ER_LEN = 800000
) (
  input  logic         clk,
  input  logic         rstN,
  input  guardStrobe_t strobe,
  input  logic         hostSel,
  input  logic         hostWr,
  input  logic         hostOe,
  output logic         wpDone,
  output logic         erDone,
  output logic         memSel,
  output logic         memWr,
  output logic         memOe,
  output logic         outDisable
);

  localparam int MAX_LEN = (WP_LEN > ER_LEN) ? WP_LEN : ER_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_LEN - 1);
  localparam logic [CNT_W-1:0] ER_LAST  = CNT_W'(ER_LEN - 1);
  localparam logic [CNT_W-1:0] MAX_LAST = CNT_W'(MAX_LEN - 1);

  logic [CNT_W-1:0] intervalCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strobe.cntClr) begin
      intervalCnt <= '0;
    end else if (strobe.cntInc && intervalCnt != MAX_LAST) begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  assign wpDone = (intervalCnt == WP_LAST);
  assign erDone = (intervalCnt == ER_LAST);

  // access gating
  logic selGated;
  assign selGated   = hostSel & strobe.gateOpen;
  assign memSel     = selGated;
  assign memWr      = selGated & hostWr;
  assign memOe      = selGated & hostOe & ~hostWr;
  assign outDisable = ~memOe;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= MAX_LAST); // R10

  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.protect |-> (!memWr && !memSel)); // R6

  AST_HIZ_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.protect |-> (outDisable && !memOe)); // R6

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lowDeselect,
  input  logic         lowSwitch,
  input  logic         hostSel,
  input  logic         wpDone,
  input  logic         erDone,
  output guardStrobe_t strobe,
  output logic         battSel,
  output logic         protectOn
);

  guardState_t state, nextState;
  logic        firstSeen;
  logic        supplyBad;
  logic        battCond;

  // switchover flag alone still counts as failure
  assign supplyBad = lowDeselect | lowSwitch;
  assign battCond  = lowDeselect & lowSwitch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PROTECT;
      firstSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (!supplyBad) firstSeen <= 1'b1;
    end
  end

  always_comb begin
    nextState     = state;
    strobe        = '0;
    unique case (state)
      ST_NORMAL: begin
        if (supplyBad) begin
          if (hostSel) begin
            nextState     = ST_PENDING;
            strobe.cntClr = 1'b1;
          end else begin
            nextState = ST_PROTECT;
          end
        end
      end
      ST_PENDING: begin
        if (!hostSel || wpDone) nextState = ST_PROTECT;
        else                    strobe.cntInc = 1'b1;
      end
      ST_PROTECT: begin
        if (battCond && firstSeen) begin
          nextState = ST_BATTERY;
        end else if (!supplyBad) begin
          nextState     = ST_RECOVER;
          strobe.cntClr = 1'b1;
        end
      end
      ST_BATTERY: begin
        if (!battCond) nextState = ST_PROTECT;
      end
      ST_RECOVER: begin
        if (supplyBad)   nextState = ST_PROTECT;
        else if (erDone) nextState = ST_NORMAL;
        else             strobe.cntInc = 1'b1;
      end
      default: nextState = ST_PROTECT;
    endcase
    strobe.gateOpen = (state == ST_NORMAL) || (state == ST_PENDING);
    strobe.protect  = (state == ST_PROTECT) || (state == ST_BATTERY) ||
                      (state == ST_RECOVER);
  end

  assign battSel   = (state == ST_BATTERY);
  assign protectOn = strobe.protect;

  AST_BATT_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> $past(battCond)); // R7

  AST_PEND_ONLY_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PENDING) |-> $past(hostSel)); // R4

  AST_PEND_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PENDING && wpDone) |=> (state == ST_PROTECT)); // R5

  AST_RECOVER_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && supplyBad) |=> (state == ST_PROTECT)); // R11

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import supply_guard_pkg::*;
#(
  parameter int WP_CYCLES = 1000,
  parameter int ER_CYCLES = 800000,
  parameter int FAST_SIM  = 0,
  parameter int SCALE_DIV = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowDeselect,
  input  logic lowSwitch,
  input  logic hostSel,
  input  logic hostWr,
  input  logic hostOe,
  output logic memSel,
  output logic memWr,
  output logic memOe,
  output logic outDisable,
  output logic battSel,
  output logic protectOn
);

  // R12: effective interval lengths
  localparam int WP_LEN = scaleLen(WP_CYCLES, FAST_SIM, SCALE_DIV);
  localparam int ER_LEN = scaleLen(ER_CYCLES, FAST_SIM, SCALE_DIV);

  guardStrobe_t strobe;
  logic         wpDone;
  logic         erDone;

  supply_guard_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lowDeselect(lowDeselect),
    .lowSwitch  (lowSwitch),
    .hostSel    (hostSel),
    .wpDone     (wpDone),
    .erDone     (erDone),
    .strobe     (strobe),
    .battSel    (battSel),
    .protectOn  (protectOn)
  );

  supply_guard_dp #(
    .WP_LEN(WP_LEN),
    .ER_LEN(ER_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostOe    (hostOe),
    .wpDone    (wpDone),
    .erDone    (erDone),
    .memSel    (memSel),
    .memWr     (memWr),
    .memOe     (memOe),
    .outDisable(outDisable)
  );

endmodule

// File: tb/supply_guard_seq_bench.sv
module supply_guard_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WP_CYC  = 1000;
  localparam int ER_CYC  = 4000;
  localparam int DIV     = 100;
  localparam int WP      = WP_CYC / DIV;   // 10
  localparam int ER      = ER_CYC / DIV;   // 40
  localparam int WDOG    = 150000;

  // {hostSel,hostWr,hostOe} -> {memSel,memWr,memOe,outDisable}, R2
  localparam logic [6:0] PASS_VEC [8] = '{
    7'b000_0001, 7'b001_0001, 7'b010_0001, 7'b011_0001,
    7'b100_1001, 7'b101_1010, 7'b110_1101, 7'b111_1101
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowDeselect = 1'b0, lowSwitch = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0, hostOe = 1'b0;
  logic memSel, memWr, memOe, outDisable, battSel, protectOn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_guard_seq #(
    .WP_CYCLES(WP_CYC), .ER_CYCLES(ER_CYC), .FAST_SIM(1), .SCALE_DIV(DIV)
  ) u_supply_guard_seq (
    .clk(clk), .rstN(rstN), .lowDeselect(lowDeselect), .lowSwitch(lowSwitch),
    .hostSel(hostSel), .hostWr(hostWr), .hostOe(hostOe),
    .memSel(memSel), .memWr(memWr), .memOe(memOe), .outDisable(outDisable),
    .battSel(battSel), .protectOn(protectOn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host(input logic s, input logic w, input logic o);
    hostSel = s; hostWr = w; hostOe = o;
  endtask

  // counts negedges until protection falls
  task automatic countRecovery(output int n);
    n = 0;
    while (protectOn && n < 10 * ER) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WDOG);
      finishRun();
    end
  end

  initial begin
    int n;
    // R1: reset state, host active
    host(1, 1, 1);
    step(3);
    #1;
    check("R1 protect", protectOn, 1);
    check("R1 batt", battSel, 0);
    check("R1 memWr", memWr, 0);
    check("R1 memSel", memSel, 0);
    check("R1 outDisable", outDisable, 1);
    host(0, 0, 0);
    rstN = 1'b1;
    // R10: recovery after cold reset
    countRecovery(n);
    check("R10 recovery length after reset", n, ER + 1);

    // R2: pass-through table
    for (int v = 0; v < 8; v++) begin
      host(PASS_VEC[v][6], PASS_VEC[v][5], PASS_VEC[v][4]);
      #1;
      check("R2 memSel", memSel, PASS_VEC[v][3]);
      check("R2 memWr", memWr, PASS_VEC[v][2]);
      check("R2 memOe", memOe, PASS_VEC[v][1]);
      check("R2 outDisable", outDisable, PASS_VEC[v][0]);
      step(1);
    end
    host(0, 0, 0);

    // R3: idle failure protects after one edge
    lowDeselect = 1'b1;
    step(1);
    check("R3 protect after one edge", protectOn, 1);
    // R6: host ignored while protected
    host(1, 1, 1);
    #1;
    check("R6 memSel", memSel, 0);
    check("R6 memWr", memWr, 0);
    check("R6 outDisable", outDisable, 1);
    host(0, 0, 0);

    // R7: battery on both flags, off when switch flag clears
    lowSwitch = 1'b1;
    step(1);
    check("R7 batt on", battSel, 1);
    lowSwitch = 1'b0;
    step(1);
    check("R7 batt off", battSel, 0);
    check("R7 still protected", protectOn, 1);

    // R11: glitch during recovery restarts the interval
    lowDeselect = 1'b0;
    step(6);
    lowDeselect = 1'b1;
    step(1);
    check("R11 back to protect", protectOn, 1);
    lowDeselect = 1'b0;
    countRecovery(n);
    check("R11 full recovery after glitch", n, ER + 1);

    // R4: failure during access lets it finish
    host(1, 1, 0);
    lowDeselect = 1'b1;
    step(3);
    #1;
    check("R4 access continues", protectOn, 0);
    check("R4 write passes", memWr, 1);
    host(0, 0, 0);
    step(1);
    check("R4 protect after access ends", protectOn, 1);
    lowDeselect = 1'b0;
    countRecovery(n);

    // R5: window forces protection
    host(1, 1, 0);
    lowDeselect = 1'b1;
    n = 0;
    while (!protectOn && n < 10 * WP) begin
      @(negedge clk);
      n++;
    end
    check("R5 forced protect edge", n, WP + 1);
    #1;
    check("R5 write blocked", memWr, 0);
    host(0, 0, 0);
    lowDeselect = 1'b0;
    countRecovery(n);

    // R9: switch flag alone
    lowSwitch = 1'b1;
    step(1);
    check("R9 protect", protectOn, 1);
    step(4);
    check("R9 no battery", battSel, 0);
    lowSwitch = 1'b0;
    countRecovery(n);

    // R8: battery isolated before first good supply
    rstN = 1'b0;
    lowDeselect = 1'b1;
    lowSwitch = 1'b1;
    step(2);
    rstN = 1'b1;
    step(10);
    check("R8 batt isolated", battSel, 0);
    check("R8 protected", protectOn, 1);
    lowDeselect = 1'b0;
    lowSwitch = 1'b0;
    step(2);
    lowDeselect = 1'b1;
    lowSwitch = 1'b1;
    step(2);
    check("R8 batt after first power", battSel, 1);

    finishRun();
  end

endmodule